// File: doc/BRIEF.md
# Dual-Master Configuration Register Bank

This block is a small addressed register bank for a motor-control device, written and read by two masters at once: a serial-bus master (its framing is decoded elsewhere) and a local microcontroller port. Each master has a plain strobe interface: a write enable, an address, write data and a read-data bus. Reads are combinational in the same cycle. A write takes effect at the clock edge on which its strobe is high.

The bank holds these registers: a 4-bit reference trim, a converter mode register, two read-back source selects for the driver channels, and a flag that enables the engineering mode. It also holds a bit-banged port toward a serial EEPROM and two self-clearing converter request flags. The engineering flag belongs to the microcontroller alone, and it gates the EEPROM port. Each request flag sends a one-cycle start pulse toward the converter and stays set until that channel reports done.

Top module: `cfg_regbank`

## Requirements
- R1: Address 38 bits 3:0 hold the reference trim, which resets to 8 and drives `ref_trim`. Both masters can write it. Bits 7:4 read 0.
- R2: At address 42, bit 0 is the tuning-mode flag (reset 0, drives `tune_mode`) and bit 3 is the offset-select flag (reset 1, drives `offs_sel`). Bits 1 and 2 read 0 even after a write of 1. Bits 7:4 read 0.
- R3: Address 41 bit 0 is the engineering enable, with reset value 0. A write from the serial master does not change it. A microcontroller write sets or clears it. Both masters can read it.
- R4: While the enable is 1, a microcontroller write to address 40 sets `eep_dat_o` from bit 0 and `eep_clk_o` from bit 1. A microcontroller read of address 40 returns bit 1 = the clock value and bit 0 = `eep_dat_i`.
- R5: While the enable is 0, the following hold: microcontroller writes to address 40 are ignored, `eep_clk_o` is low, `eep_dat_o` is high and reads of address 40 return 0. The port register is cleared to clock 0 / data 1, and that is the state seen when the enable is set again. The serial master can never write address 40, and its reads of that address return 0.
- R6: At address 43, writing 1 to bit 0 (current/bus sampling) or to bit 1 (supply sampling) sets that pending bit. The write also raises `adc_start` for that channel for exactly one cycle, in the cycle after the write edge. A pending bit reads back 1.
- R7: A pending bit clears on its own channel's `adc_done` pulse. A done pulse on the other channel leaves it set. Writing 0 has no effect. Writing 1 while the bit is pending gives no new start pulse.
- R8: Bit 7 of address 36 selects analog read-back for driver channel 0, and bit 7 of address 37 does the same for channel 1. Both reset to 0 and drive `rb_analog[0]` and `rb_analog[1]`. The other bits read 0.
- R9: When both masters write the same register in one cycle, the microcontroller data is stored. Writes by the two masters to different registers in the same cycle are both applied.
- R10: Reads of any unmapped address (including 39) return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_we | input | 1 | Serial master write strobe |
| spi_addr | input | 6 | Serial master address |
| spi_wdata | input | 8 | Serial master write data |
| spi_rdata | output | 8 | Serial master read data |
| mcu_we | input | 1 | Microcontroller write strobe |
| mcu_addr | input | 6 | Microcontroller address |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Microcontroller read data |
| adc_start | output | 2 | One-cycle conversion start per channel |
| adc_done | input | 2 | Conversion done pulse per channel |
| eep_dat_o | output | 1 | EEPROM serial data out |
| eep_clk_o | output | 1 | EEPROM serial clock |
| eep_dat_i | input | 1 | EEPROM serial data in |
| ref_trim | output | 4 | Reference trim setting |
| tune_mode | output | 1 | Converter tuning mode |
| offs_sel | output | 1 | Offset select |
| rb_analog | output | 2 | Analog read-back select per driver channel |

## Verification
All register state is visible in the same cycle through combinational reads. A bad register value therefore appears on the next read of its address, and a bad drive output appears in the cycle after the write edge that sets it. A request bit that is stuck set or lost shows up as a missing or repeated `adc_start` pulse, or as a pending bit that does not clear one cycle after done. An access rule that leaks shows at once: the serial master changes the enable, or a disabled EEPROM port moves its clock or reads non-zero.

// File: rtl/cfg_regbank_pkg.sv
// Package: shared widths, slot indices and the address table of the bank.
// Assumes the slot order below is the only order used by every submodule.
package cfg_regbank_pkg;
    localparam int AW     = 6;
    localparam int DW     = 8;
    localparam int NSLOT  = 7;
    localparam int NCH    = 2;
    localparam int TRIM_W = 4;
    localparam logic [TRIM_W-1:0] TRIM_RST = 4'd8;

    // slot indices
    localparam int S_RBS0 = 0;   // 36, 37 follow as S_RBS0 + channel
    localparam int S_TRIM = 2;
    localparam int S_EEP  = 3;
    localparam int S_EEN  = 4;
    localparam int S_MODE = 5;
    localparam int S_REQ  = 6;

    // address of each slot, index 0 rightmost
    localparam logic [NSLOT-1:0][AW-1:0] SLOT_ADDR =
        {6'd43, 6'd42, 6'd41, 6'd40, 6'd38, 6'd37, 6'd36};

    // serial master may write/read a slot only where the bit is 1
    localparam logic [NSLOT-1:0] SPI_WMASK = 7'b1100111;
    localparam logic [NSLOT-1:0] SPI_RMASK = 7'b1110111;
endpackage

// File: rtl/cfg_wr_merge.sv
// Write merge: turns the two masters' strobes into one write enable and
// one data word per slot. Applies the access rules and gives the
// microcontroller priority on a collision. Assumes addresses in SLOT_ADDR are distinct.
module cfg_wr_merge #(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int NSLOT = 7,
    parameter int EEP_SLOT = 3,
    parameter logic [NSLOT-1:0][AW-1:0] SLOT_ADDR = '0,
    parameter logic [NSLOT-1:0] SPI_WMASK = '0
) (
    input  logic                      spi_we,
    input  logic [AW-1:0]             spi_addr,
    input  logic [DW-1:0]             spi_wdata,
    input  logic                      mcu_we,
    input  logic [AW-1:0]             mcu_addr,
    input  logic [DW-1:0]             mcu_wdata,
    input  logic                      eep_en,
    output logic [NSLOT-1:0]          slot_we,
    output logic [NSLOT-1:0][DW-1:0]  slot_wd
);
    logic [NSLOT-1:0] spi_hit;
    logic [NSLOT-1:0] mcu_hit;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam bit IS_EEP = (s == EEP_SLOT);
        // serial hit honours its write mask
        assign spi_hit[s] = spi_we && (spi_addr == SLOT_ADDR[s]) && SPI_WMASK[s];
        // microcontroller hit; the EEPROM slot needs the enable
        assign mcu_hit[s] = mcu_we && (mcu_addr == SLOT_ADDR[s]) && (!IS_EEP || eep_en);
        assign slot_we[s] = spi_hit[s] | mcu_hit[s];
        // microcontroller data wins on a shared slot
        assign slot_wd[s] = mcu_hit[s] ? mcu_wdata : spi_wdata;
    end
endmodule

// File: rtl/cfg_adc_req.sv
// Converter request flags: one pending bit per channel. It is set by a
// write of 1, emits a one-cycle start pulse and clears on that channel's done.
// Assumes done arrives as a pulse and is ignored while idle.
module cfg_adc_req #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_we,
    input  logic [NCH-1:0] req_wd,
    input  logic [NCH-1:0] adc_done,
    output logic [NCH-1:0] pend,
    output logic [NCH-1:0] adc_start
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // pending flag and start pulse of one channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[c]      <= 1'b0;
                adc_start[c] <= 1'b0;
            end else begin
                adc_start[c] <= 1'b0;
                if (pend[c]) begin
                    if (adc_done[c]) pend[c] <= 1'b0;
                end else if (req_we && req_wd[c]) begin
                    pend[c]      <= 1'b1;
                    adc_start[c] <= 1'b1;
                end
            end
        end

        // R6
        start_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            adc_start[c] |-> pend[c]);
        // R6
        start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            adc_start[c] |=> !adc_start[c]);
        // R7
        done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[c] && adc_done[c]) |=> !pend[c]);
    end
endmodule

// File: rtl/cfg_eep_port.sv
// Bit-banged EEPROM port. It is held at clock 0 / data 1 while disabled,
// and it follows microcontroller writes while enabled.
// Assumes the write strobe is already qualified by the enable upstream.
module cfg_eep_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       we,
    input  logic [1:0] wd,
    input  logic       dat_i,
    output logic       dat_o,
    output logic       clk_o,
    output logic [1:0] rd
);
    logic dat_q, clk_q;

    // port register, parked while the enable is low
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            dat_q <= 1'b1;
            clk_q <= 1'b0;
        end else if (we) begin
            dat_q <= wd[0];
            clk_q <= wd[1];
        end
    end

    assign clk_o = clk_q & en;
    assign dat_o = en ? dat_q : 1'b1;
    assign rd    = en ? {clk_q, dat_i} : 2'b00;

    // R5
    parked_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (clk_q == 1'b0 && dat_q == 1'b1));
    // R4
    drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (!en || (clk_o == $past(wd[1]) && dat_o == $past(wd[0]))));
endmodule

// File: rtl/cfg_regbank.sv
// Top of the dual-master configuration bank. It merges the writes, holds
// the plain registers and builds the read views for each master.
// Assumes a synchronous active-low reset and single-cycle write strobes.
module cfg_regbank
    import cfg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_we,
    input  logic [AW-1:0]     spi_addr,
    input  logic [DW-1:0]     spi_wdata,
    output logic [DW-1:0]     spi_rdata,
    input  logic              mcu_we,
    input  logic [AW-1:0]     mcu_addr,
    input  logic [DW-1:0]     mcu_wdata,
    output logic [DW-1:0]     mcu_rdata,
    output logic [NCH-1:0]    adc_start,
    input  logic [NCH-1:0]    adc_done,
    output logic              eep_dat_o,
    output logic              eep_clk_o,
    input  logic              eep_dat_i,
    output logic [TRIM_W-1:0] ref_trim,
    output logic              tune_mode,
    output logic              offs_sel,
    output logic [NCH-1:0]    rb_analog
);
    logic [NSLOT-1:0]         slot_we;
    logic [NSLOT-1:0][DW-1:0] slot_wd;
    logic [NSLOT-1:0][DW-1:0] rd_slot;
    logic                     een_q;
    logic [TRIM_W-1:0]        trim_q;
    logic                     tune_q, offs_q;
    logic [NCH-1:0]           rbs_q;
    logic [NCH-1:0]           pend;
    logic [1:0]               eep_rd;
    logic                     unused_wd;

    cfg_wr_merge #(
        .AW(AW), .DW(DW), .NSLOT(NSLOT), .EEP_SLOT(S_EEP),
        .SLOT_ADDR(SLOT_ADDR), .SPI_WMASK(SPI_WMASK)
    ) u_merge (
        .spi_we(spi_we), .spi_addr(spi_addr), .spi_wdata(spi_wdata),
        .mcu_we(mcu_we), .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
        .eep_en(een_q), .slot_we(slot_we), .slot_wd(slot_wd)
    );

    cfg_adc_req #(.NCH(NCH)) u_req (
        .clk(clk), .rst_n(rst_n),
        .req_we(slot_we[S_REQ]), .req_wd(slot_wd[S_REQ][NCH-1:0]),
        .adc_done(adc_done), .pend(pend), .adc_start(adc_start)
    );

    cfg_eep_port u_eep (
        .clk(clk), .rst_n(rst_n), .en(een_q),
        .we(slot_we[S_EEP]), .wd(slot_wd[S_EEP][1:0]),
        .dat_i(eep_dat_i), .dat_o(eep_dat_o), .clk_o(eep_clk_o), .rd(eep_rd)
    );

    // read-back source selects, one register per driver channel
    for (genvar c = 0; c < NCH; c++) begin : g_rbs
        always_ff @(posedge clk) begin
            if (!rst_n)                    rbs_q[c] <= 1'b0;
            else if (slot_we[S_RBS0 + c])  rbs_q[c] <= slot_wd[S_RBS0 + c][DW-1];
        end
        assign rd_slot[S_RBS0 + c] = {rbs_q[c], {(DW-1){1'b0}}};
    end

    // reference trim register
    always_ff @(posedge clk) begin
        if (!rst_n)               trim_q <= TRIM_RST;
        else if (slot_we[S_TRIM]) trim_q <= slot_wd[S_TRIM][TRIM_W-1:0];
    end

    // engineering enable; the merge only lets the microcontroller reach it
    always_ff @(posedge clk) begin
        if (!rst_n)              een_q <= 1'b0;
        else if (slot_we[S_EEN]) een_q <= slot_wd[S_EEN][0];
    end

    // mode register; reserved bits 1 and 2 are never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tune_q <= 1'b0;
            offs_q <= 1'b1;
        end else if (slot_we[S_MODE]) begin
            tune_q <= slot_wd[S_MODE][0];
            offs_q <= slot_wd[S_MODE][3];
        end
    end

    // read values of the remaining slots
    always_comb begin
        rd_slot[S_TRIM] = DW'(trim_q);
        rd_slot[S_EEP]  = DW'(eep_rd);
        rd_slot[S_EEN]  = DW'(een_q);
        rd_slot[S_MODE] = DW'({offs_q, 2'b00, tune_q});
        rd_slot[S_REQ]  = DW'(pend);
    end

    // read views of both masters, unmapped addresses give 0
    always_comb begin
        spi_rdata = '0;
        mcu_rdata = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (spi_addr == SLOT_ADDR[s] && SPI_RMASK[s]) spi_rdata = rd_slot[s];
            if (mcu_addr == SLOT_ADDR[s])                 mcu_rdata = rd_slot[s];
        end
    end

    assign ref_trim  = trim_q;
    assign tune_mode = tune_q;
    assign offs_sel  = offs_q;
    assign rb_analog = rbs_q;
    assign unused_wd = ^slot_wd;

    // R1
    trim_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ref_trim == TRIM_RST && offs_sel && !tune_mode));
    // R3
    een_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(een_q) |-> $past(mcu_we && mcu_addr == SLOT_ADDR[S_EEN]));
    // R2
    mode_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_addr == SLOT_ADDR[S_MODE]) |-> (mcu_rdata[2:1] == 2'b00));
    // R9
    mcu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_we && mcu_we && spi_addr == SLOT_ADDR[S_TRIM] && mcu_addr == SLOT_ADDR[S_TRIM])
        |=> ref_trim == $past(mcu_wdata[TRIM_W-1:0]));
    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_addr == 6'd39) |-> (mcu_rdata == '0));
endmodule

// File: tb/cfg_regbank_test.sv
module cfg_regbank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_we = 1'b0, mcu_we = 1'b0;
    logic [5:0] spi_addr = '0, mcu_addr = '0;
    logic [7:0] spi_wdata = '0, mcu_wdata = '0;
    logic [7:0] spi_rdata, mcu_rdata;
    logic [1:0] adc_start;
    logic [1:0] adc_done = '0;
    logic       eep_dat_o, eep_clk_o;
    logic       eep_dat_i = 1'b1;
    logic [3:0] ref_trim;
    logic       tune_mode, offs_sel;
    logic [1:0] rb_analog;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cfg_regbank uut (
        .clk(clk), .rst_n(rst_n),
        .spi_we(spi_we), .spi_addr(spi_addr), .spi_wdata(spi_wdata), .spi_rdata(spi_rdata),
        .mcu_we(mcu_we), .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
        .adc_start(adc_start), .adc_done(adc_done),
        .eep_dat_o(eep_dat_o), .eep_clk_o(eep_clk_o), .eep_dat_i(eep_dat_i),
        .ref_trim(ref_trim), .tune_mode(tune_mode), .offs_sel(offs_sel), .rb_analog(rb_analog)
    );

    typedef struct packed {
        logic       mcu;
        logic       we;
        logic [5:0] addr;
        logic [7:0] wd;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 6'd38, 8'h05, 8'h05, 8'd1},   // R1 serial write trim
        '{1'b1, 1'b1, 6'd38, 8'hFA, 8'h0A, 8'd1},   // R1 upper bits read 0
        '{1'b0, 1'b1, 6'd42, 8'h0F, 8'h09, 8'd2},   // R2 reserved masked
        '{1'b1, 1'b1, 6'd42, 8'h06, 8'h00, 8'd2},   // R2 reserved only
        '{1'b0, 1'b1, 6'd41, 8'h01, 8'h00, 8'd3},   // R3 serial cannot set
        '{1'b1, 1'b1, 6'd41, 8'h01, 8'h01, 8'd3},   // R3 mcu sets
        '{1'b0, 1'b0, 6'd41, 8'h00, 8'h01, 8'd3},   // R3 serial reads it
        '{1'b1, 1'b1, 6'd40, 8'h02, 8'h03, 8'd4},   // R4 clk=1, dat_i=1
        '{1'b0, 1'b1, 6'd40, 8'h00, 8'h00, 8'd5},   // R5 serial blocked
        '{1'b1, 1'b0, 6'd40, 8'h00, 8'h03, 8'd5},   // R5 port unchanged
        '{1'b1, 1'b1, 6'd36, 8'h80, 8'h80, 8'd8},   // R8 channel 0
        '{1'b0, 1'b1, 6'd37, 8'hFF, 8'h80, 8'd8},   // R8 channel 1
        '{1'b1, 1'b1, 6'd39, 8'hFF, 8'h00, 8'd10},  // R10 address 39
        '{1'b0, 1'b1, 6'd05, 8'hFF, 8'h00, 8'd10},  // R10 address 5
        '{1'b0, 1'b0, 6'd38, 8'h00, 8'h0A, 8'd10}   // R10 trim untouched
    };

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic wr2(input logic sw, input logic [5:0] sa, input logic [7:0] sd,
                       input logic mw, input logic [5:0] ma, input logic [7:0] md);
        @(negedge clk);
        spi_we = sw; spi_addr = sa; spi_wdata = sd;
        mcu_we = mw; mcu_addr = ma; mcu_wdata = md;
        @(negedge clk);
        spi_we = 1'b0; mcu_we = 1'b0;
    endtask

    task automatic rd(input logic m, input logic [5:0] a, output logic [7:0] d);
        if (m) mcu_addr = a; else spi_addr = a;
        #2;
        d = m ? mcu_rdata : spi_rdata;
    endtask

    initial begin : main
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(1, 6'd38, d); chk(d, 8'h08, "R1 trim reset");
        rd(1, 6'd42, d); chk(d, 8'h08, "R2 mode reset");
        rd(1, 6'd41, d); chk(d, 8'h00, "R3 enable reset");
        rd(1, 6'd40, d); chk(d, 8'h00, "R5 port reads 0 at reset");
        rd(0, 6'd43, d); chk(d, 8'h00, "R6 no pending at reset");
        rd(0, 6'd36, d); chk(d, 8'h00, "R8 select reset");
        chk({4'b0, ref_trim}, 8'h08, "R1 ref_trim reset");
        chk({6'b0, offs_sel, tune_mode}, 8'h02, "R2 mode outputs reset");
        chk({6'b0, eep_clk_o, eep_dat_o}, 8'h01, "R5 port parked at reset");
        chk({6'b0, adc_start}, 8'h00, "R6 no start at reset");

        // vector walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) begin
                if (VEC[i].mcu) wr2(1'b0, 6'd0, 8'h00, 1'b1, VEC[i].addr, VEC[i].wd);
                else            wr2(1'b1, VEC[i].addr, VEC[i].wd, 1'b0, 6'd0, 8'h00);
            end
            rd(VEC[i].mcu, VEC[i].addr, d);
            chk(d, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
        end
        chk({4'b0, ref_trim}, 8'h0A, "R1 ref_trim output");
        chk({6'b0, offs_sel, tune_mode}, 8'h00, "R2 mode outputs");
        chk({6'b0, rb_analog}, 8'h03, "R8 rb_analog output");
        chk({6'b0, eep_clk_o, eep_dat_o}, 8'h02, "R4 port outputs");
        eep_dat_i = 1'b0;
        rd(1, 6'd40, d); chk(d, 8'h02, "R4 data input read");

        // R5 disabled port
        wr2(0, 6'd0, 8'h00, 1, 6'd41, 8'h00);
        chk({6'b0, eep_clk_o, eep_dat_o}, 8'h01, "R5 parked after disable");
        rd(1, 6'd40, d); chk(d, 8'h00, "R5 read while disabled");
        wr2(0, 6'd0, 8'h00, 1, 6'd40, 8'h03);
        chk({6'b0, eep_clk_o, eep_dat_o}, 8'h01, "R5 write ignored");
        eep_dat_i = 1'b1;
        wr2(0, 6'd0, 8'h00, 1, 6'd41, 8'h01);
        rd(1, 6'd40, d); chk(d, 8'h01, "R5 port cleared on re-enable");
        wr2(0, 6'd0, 8'h00, 1, 6'd40, 8'h01);
        chk({6'b0, eep_clk_o, eep_dat_o}, 8'h01, "R4 data 1 clock 0");

        // R9 collisions
        wr2(1, 6'd38, 8'h01, 1, 6'd38, 8'h02);
        rd(1, 6'd38, d); chk(d, 8'h02, "R9 mcu wins trim");
        wr2(1, 6'd38, 8'h03, 1, 6'd36, 8'h00);
        rd(1, 6'd38, d); chk(d, 8'h03, "R9 serial applied");
        rd(1, 6'd36, d); chk(d, 8'h00, "R9 mcu applied");
        wr2(1, 6'd41, 8'h01, 1, 6'd41, 8'h00);
        rd(1, 6'd41, d); chk(d, 8'h00, "R9 mcu wins enable");

        // R6 / R7 request flags
        wr2(0, 6'd0, 8'h00, 1, 6'd43, 8'h01);
        chk({6'b0, adc_start}, 8'h01, "R6 start pulse ch0");
        rd(1, 6'd43, d); chk(d, 8'h01, "R6 pending ch0");
        @(negedge clk);
        chk({6'b0, adc_start}, 8'h00, "R6 pulse one cycle");
        wr2(0, 6'd0, 8'h00, 1, 6'd43, 8'h01);
        chk({6'b0, adc_start}, 8'h00, "R7 no re-pulse while pending");
        wr2(0, 6'd0, 8'h00, 1, 6'd43, 8'h00);
        rd(1, 6'd43, d); chk(d, 8'h01, "R7 write 0 no effect");
        wr2(1, 6'd43, 8'h02, 0, 6'd0, 8'h00);
        chk({6'b0, adc_start}, 8'h02, "R6 start pulse ch1");
        @(negedge clk); adc_done = 2'b01;
        @(negedge clk); adc_done = 2'b00;
        rd(1, 6'd43, d); chk(d, 8'h02, "R7 done clears own channel only");
        @(negedge clk); adc_done = 2'b10;
        @(negedge clk); adc_done = 2'b00;
        rd(0, 6'd43, d); chk(d, 8'h00, "R7 done clears ch1");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule